// File: doc/BRIEF.md
# Transition-coded byte link hop with route stripping and CRC-8

This block is one switch input and one switch output of a byte-wide point-to-point link, joined through a small buffer. On each line, characters travel as nine transition-coded wires plus a stop wire in the opposite direction. The nine wires are eight data bits and one data/control flag. A bit that is 1 in a character toggles its wire. Nothing toggles when the line is idle. The flag is 1 for every data byte, so each data byte produces at least one edge, even when its value is zero. The receiver compares the lines with their values in the previous cycle. It takes in a character in any cycle where something changed, so the sender may leave gaps of any length.

A packet arrives as a route byte, then the body bytes, then a CRC-8 trailer, all sent as data characters, and then the control character 0x01. The hop takes the leading route byte off and reports it. It checks the trailer against a running CRC. It forwards only the body downstream, where it appends a CRC newly computed over the bytes it actually sent. A packet that fails the check still goes out, but with its trailer inverted, so the next hop also rejects it. Each direction has its own stop line. The hop raises its upstream stop early enough to absorb the characters still in flight. It halts its own sending one cycle after its downstream neighbour raises stop.

Top module: `tglink_hop`

## Requirements
- R1: Downstream encoding: a data character toggles `dn_flag` together with each `dn_data` bit that is 1 in the byte. The only control character sent is 0x01, which toggles `dn_data[0]` and leaves `dn_flag` unchanged. The lines never change while nothing is being sent.
- R2: The receiver takes in a character in every cycle in which `up_data` or `up_flag` differs from its value in the previous cycle. The character is `up_data` XOR previous `up_data`, and it is a data character when `up_flag` toggled. Idle gaps of any length between characters are allowed.
- R3: The first data character after reset, or after a terminator, is the route byte. It appears on `hop_route` with a one-cycle `hop_route_vld` pulse and is not forwarded.
- R4: Every data character after the route byte, except the last one before the terminator, is forwarded downstream as a data character, in arrival order.
- R5: After the forwarded body, the hop sends a trailer data byte and then the control character 0x01. The trailer is the CRC-8 over the forwarded body: polynomial x^8+x^2+x+1 (0x07), initial value 0x00, most significant bit first, no final inversion.
- R6: On the upstream terminator (control 0x01), `pkt_done` pulses for one cycle. `pkt_crc_err` is high with it when fewer than two data characters arrived, or when the last data character differs from the CRC-8 of R5 taken over the route byte and all the body bytes.
- R7: When the upstream check fails and a route byte was received, the downstream trailer is the bitwise inverse of the CRC of R5. A terminator with no route byte before it produces no downstream output.
- R8: Upstream control characters other than 0x01 are discarded. They change neither the forwarded bytes, nor the trailer, nor the outcome of the check.
- R9: If `dn_stop` was high at clock edge k, the hop issues no character at edge k+1. At most one character follows the rise of `dn_stop`.
- R10: `up_stop` goes high once the buffer holds DEPTH-SLACK entries. A sender that issues up to two further characters after seeing it loses nothing.
- R11: After reset, `up_stop`, `dn_data`, `dn_flag`, `hop_route_vld`, `pkt_done` and `pkt_crc_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_data | input | 8 | Transition-coded data bits from the upstream link |
| up_flag | input | 1 | Transition-coded data/control flag from upstream |
| up_stop | output | 1 | Flow-control stop towards the upstream sender |
| dn_data | output | 8 | Transition-coded data bits to the downstream link |
| dn_flag | output | 1 | Transition-coded data/control flag downstream |
| dn_stop | input | 1 | Flow-control stop from the downstream receiver |
| hop_route | output | 8 | Route byte taken off the current packet |
| hop_route_vld | output | 1 | One-cycle pulse when `hop_route` is updated |
| pkt_done | output | 1 | One-cycle pulse on each upstream terminator |
| pkt_crc_err | output | 1 | Check result, valid with `pkt_done` |

## Verification
A route byte of 0x00 and body bytes of 0x00 and 0x01 are sent with idle gaps between them. A receiver that relied on data-wire edges alone would lose the zero bytes. One that confused a data 0x01 with the terminator would cut the packet short. A packet with a bad trailer, a packet with only a route byte, and a terminator arriving alone expose a check that overlooks short packets, or a hop that passes bad packets on with a valid CRC. Control characters other than the terminator are placed in mid-packet, where a careless receiver would forward them or fold them into the CRC. Backpressure tests hold and toggle the downstream stop while a packet longer than the buffer arrives. A hop that sent late after stop, raised its own stop too late, or overran its buffer would show extra characters, or missing or reordered bytes, downstream.

// File: rtl/tglink_hop.sv
module tglink_hop #(
  parameter int DEPTH = 16,
  parameter int SLACK = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] up_data,
  input  logic       up_flag,
  output logic       up_stop,
  output logic [7:0] dn_data,
  output logic       dn_flag,
  input  logic       dn_stop,
  output logic [7:0] hop_route,
  output logic       hop_route_vld,
  output logic       pkt_done,
  output logic       pkt_crc_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int THR = DEPTH - SLACK;
  localparam logic [7:0] EOP = 8'h01;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  // receive side
  logic [7:0] up_d_q;
  logic       up_f_q;
  logic       route_seen, pend_v;
  logic [7:0] pend, crc_run;

  wire [7:0] rx_bits   = up_data ^ up_d_q;
  wire       rx_isdata = up_flag ^ up_f_q;
  wire       rx_char   = rx_isdata | (|rx_bits);
  wire       rx_eop    = !rx_isdata && (rx_bits == EOP);
  wire       trail_ok  = route_seen && pend_v && (pend == crc_run);

  logic       wr_req;
  logic [8:0] wr_ent;

  always_comb begin
    wr_req = 1'b0;
    wr_ent = '0;
    if (rx_char && rx_isdata && route_seen && pend_v) begin
      wr_req = 1'b1;
      wr_ent = {1'b0, pend};
    end else if (rx_eop && route_seen) begin
      wr_req = 1'b1;
      wr_ent = {1'b1, 7'd0, !trail_ok};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_d_q        <= '0;
      up_f_q        <= 1'b0;
      route_seen    <= 1'b0;
      pend_v        <= 1'b0;
      pend          <= '0;
      crc_run       <= '0;
      hop_route     <= '0;
      hop_route_vld <= 1'b0;
      pkt_done      <= 1'b0;
      pkt_crc_err   <= 1'b0;
    end else begin
      up_d_q        <= up_data;
      up_f_q        <= up_flag;
      hop_route_vld <= 1'b0;
      pkt_done      <= 1'b0;
      pkt_crc_err   <= 1'b0;
      if (rx_char) begin
        if (rx_isdata) begin
          if (!route_seen) begin
            hop_route     <= rx_bits;
            hop_route_vld <= 1'b1;
            route_seen    <= 1'b1;
            crc_run       <= crc8(8'h00, rx_bits);
          end else begin
            if (pend_v) crc_run <= crc8(crc_run, pend);
            pend   <= rx_bits;
            pend_v <= 1'b1;
          end
        end else if (rx_eop) begin
          pkt_done    <= 1'b1;
          pkt_crc_err <= !trail_ok;
          route_seen  <= 1'b0;
          pend_v      <= 1'b0;
        end
      end
    end
  end

  // buffer
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_rd;

  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);
  wire do_wr = wr_req && !full;
  wire [8:0] head = mem[rp];

  assign up_stop = (cnt >= CW'(THR));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // transmit side
  logic       stop_s, tx_term;
  logic [7:0] crc_tx;
  logic       tx_isdata, tx_pop;
  logic [7:0] tx_byte;

  wire tx_go = !stop_s && (tx_term || !empty);

  always_comb begin
    if (tx_term) begin
      tx_isdata = 1'b0;
      tx_byte   = EOP;
      tx_pop    = 1'b1;
    end else if (head[8]) begin
      tx_isdata = 1'b1;
      tx_byte   = crc_tx ^ {8{head[0]}};
      tx_pop    = 1'b0;
    end else begin
      tx_isdata = 1'b1;
      tx_byte   = head[7:0];
      tx_pop    = 1'b1;
    end
  end

  assign do_rd = tx_go && tx_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_s  <= 1'b0;
      tx_term <= 1'b0;
      crc_tx  <= '0;
      dn_data <= '0;
      dn_flag <= 1'b0;
    end else begin
      stop_s <= dn_stop;
      if (tx_go) begin
        dn_data <= dn_data ^ tx_byte;
        dn_flag <= dn_flag ^ tx_isdata;
        if (tx_term) begin
          tx_term <= 1'b0;
          crc_tx  <= '0;
        end else if (head[8]) begin
          tx_term <= 1'b1;
        end else begin
          crc_tx <= crc8(crc_tx, head[7:0]);
        end
      end
    end
  end
endmodule

module tglink_hop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dn_stop,
  input logic [7:0] dn_data,
  input logic       dn_flag,
  input logic       hop_route_vld,
  input logic       pkt_done,
  input logic       pkt_crc_err,
  input logic       wr_req,
  input logic       full
);
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dn_stop, 2) |-> ($stable(dn_data) && $stable(dn_flag))); // R9

  AST_CTRL_IS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dn_data) && $stable(dn_flag)) |-> ((dn_data ^ $past(dn_data)) == 8'h01)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !full); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_crc_err |-> pkt_done); // R6

  AST_ROUTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hop_route_vld |=> !hop_route_vld); // R3
endmodule

bind tglink_hop tglink_hop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dn_stop(dn_stop), .dn_data(dn_data),
  .dn_flag(dn_flag), .hop_route_vld(hop_route_vld), .pkt_done(pkt_done),
  .pkt_crc_err(pkt_crc_err), .wr_req(wr_req), .full(full)
);

// File: tb/tglink_hop_tb.sv
module tglink_hop_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] up_data = '0;
  logic       up_flag = 1'b0;
  logic       up_stop;
  logic [7:0] dn_data;
  logic       dn_flag;
  logic       dn_stop = 1'b0;
  logic [7:0] hop_route;
  logic       hop_route_vld, pkt_done, pkt_crc_err;

  tglink_hop u_dut (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_flag(up_flag), .up_stop(up_stop),
    .dn_data(dn_data), .dn_flag(dn_flag), .dn_stop(dn_stop), .hop_route(hop_route),
    .hop_route_vld(hop_route_vld), .pkt_done(pkt_done), .pkt_crc_err(pkt_crc_err)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  // downstream monitor
  logic [8:0] dnq [0:255];
  int ndn = 0, nroute = 0, ndone = 0, stop_viol = 0;
  logic [7:0] route_got = '0;
  bit last_err = 0, saw_up_stop = 0;
  logic [7:0] pd = '0;
  logic pf = 1'b0;
  logic [1:0] sh = '0;

  always @(posedge clk) sh <= {sh[0], dn_stop};

  always @(negedge clk) begin : mon
    logic [7:0] dd;
    logic df;
    if (rst_n) begin
      dd = dn_data ^ pd;
      df = dn_flag ^ pf;
      pd = dn_data;
      pf = dn_flag;
      if (df || dd != 0) begin
        if (sh[1]) stop_viol++;
        if (ndn < 256) dnq[ndn] = {df, dd};
        ndn++;
      end
      if (hop_route_vld) begin route_got = hop_route; nroute++; end
      if (pkt_done) begin ndone++; last_err = pkt_crc_err; end
      if (up_stop) saw_up_stop = 1;
    end
  end

  // upstream sender: may issue two more characters after seeing stop
  logic [7:0] ud = '0;
  logic uf = 1'b0;
  int after_stop = 0, gap = 0;
  logic [7:0] body [0:63];

  task automatic put(input bit isd, input logic [7:0] b);
    @(negedge clk);
    while (up_stop && after_stop >= 2) @(negedge clk);
    if (up_stop) after_stop++; else after_stop = 0;
    ud = ud ^ b;
    uf = uf ^ isd;
    up_data = ud;
    up_flag = uf;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] route, input int n, input bit bad, input bit junk);
    logic [7:0] c;
    c = ref_crc(8'h00, route);
    put(1'b1, route);
    for (int i = 0; i < n; i++) begin
      put(1'b1, body[i]);
      c = ref_crc(c, body[i]);
      if (junk && i == 1) begin put(1'b0, 8'h05); put(1'b0, 8'h80); end
    end
    put(1'b1, bad ? (c ^ 8'h5A) : c);
    put(1'b0, 8'h01);
  endtask

  task automatic clear_mon();
    ndn = 0; nroute = 0; ndone = 0; saw_up_stop = 0;
  endtask

  task automatic check_out(input string req, input int n, input bit bad);
    logic [7:0] c;
    int w;
    w = 0;
    while (ndn < n + 2 && w < 3000) begin @(negedge clk); w++; end
    repeat (10) @(negedge clk);
    chk(ndn == n + 2, req, "downstream char count", ndn, n + 2);
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      chk(dnq[i] == {1'b1, body[i]}, "R4 R1", "forwarded data char", int'(dnq[i]), int'({1'b1, body[i]}));
      c = ref_crc(c, body[i]);
    end
    if (bad) c = ~c;
    chk(dnq[n] == {1'b1, c}, bad ? "R7" : "R5", "downstream trailer", int'(dnq[n]), int'({1'b1, c}));
    chk(dnq[n + 1] == 9'h001, "R5 R1", "downstream terminator", int'(dnq[n + 1]), 1);
  endtask

  task automatic t_reset();
    chk(up_stop == 0 && dn_data == 0 && dn_flag == 0, "R11", "line outputs after reset",
        int'({up_stop, dn_flag, dn_data}), 0);
    chk(hop_route_vld == 0 && pkt_done == 0 && pkt_crc_err == 0, "R11", "pulses after reset",
        int'({hop_route_vld, pkt_done, pkt_crc_err}), 0);
    repeat (5) @(negedge clk);
    chk(ndn == 0, "R1", "idle line quiet", ndn, 0);
  endtask

  task automatic t_basic();
    clear_mon();
    gap = 0;
    body[0] = 8'h11; body[1] = 8'h22; body[2] = 8'h33; body[3] = 8'hC4;
    send_pkt(8'h3A, 4, 1'b0, 1'b0);
    check_out("R4", 4, 1'b0);
    chk(nroute == 1 && route_got == 8'h3A, "R3", "route byte", int'(route_got), 8'h3A);
    chk(ndone == 1 && last_err == 0, "R6", "good packet check", int'(last_err), 0);
  endtask

  task automatic t_gaps();
    clear_mon();
    gap = 3;
    body[0] = 8'h00; body[1] = 8'hFF; body[2] = 8'h01; body[3] = 8'h00; body[4] = 8'h80;
    send_pkt(8'h00, 5, 1'b0, 1'b0);
    gap = 0;
    check_out("R2", 5, 1'b0);
    chk(nroute == 1 && route_got == 8'h00, "R2", "zero route with gaps", int'(route_got), 0);
    chk(ndone == 1 && last_err == 0, "R2", "zero bytes kept in check", int'(last_err), 0);
  endtask

  task automatic t_bad();
    clear_mon();
    body[0] = 8'hA5; body[1] = 8'h5A; body[2] = 8'h77;
    send_pkt(8'h09, 3, 1'b1, 1'b0);
    check_out("R7", 3, 1'b1);
    chk(ndone == 1 && last_err == 1, "R6", "bad trailer flagged", int'(last_err), 1);
  endtask

  task automatic t_ctrl();
    clear_mon();
    body[0] = 8'h10; body[1] = 8'h20; body[2] = 8'h30; body[3] = 8'h40;
    send_pkt(8'h44, 4, 1'b0, 1'b1);
    check_out("R8", 4, 1'b0);
    chk(ndone == 1 && last_err == 0, "R8", "other control chars ignored by check", int'(last_err), 0);
  endtask

  task automatic t_short();
    clear_mon();
    put(1'b1, 8'h61);
    put(1'b0, 8'h01);
    check_out("R7", 0, 1'b1);
    chk(ndone == 1 && last_err == 1, "R6", "route-only packet flagged", int'(last_err), 1);
    clear_mon();
    put(1'b0, 8'h01);
    repeat (20) @(negedge clk);
    chk(ndone == 1 && last_err == 1, "R6", "bare terminator flagged", int'(last_err), 1);
    chk(ndn == 0, "R7", "bare terminator forwards nothing", ndn, 0);
  endtask

  task automatic t_bp();
    clear_mon();
    for (int i = 0; i < 30; i++) body[i] = 8'(i * 7 + 3);
    @(negedge clk);
    dn_stop = 1'b1;
    repeat (3) @(negedge clk);
    fork
      send_pkt(8'h2B, 30, 1'b0, 1'b0);
      begin
        repeat (80) @(negedge clk);
        chk(ndn == 0, "R9", "no output while stopped", ndn, 0);
        chk(saw_up_stop == 1, "R10", "upstream stop raised", int'(saw_up_stop), 1);
        dn_stop = 1'b0;
      end
    join
    check_out("R10", 30, 1'b0);
    chk(ndone == 1 && last_err == 0, "R10", "no loss under backpressure", int'(last_err), 0);
  endtask

  task automatic t_toggle();
    bit busy;
    clear_mon();
    for (int i = 0; i < 20; i++) body[i] = 8'(8'hE1 ^ (i * 13));
    busy = 1;
    fork
      begin send_pkt(8'h7E, 20, 1'b0, 1'b0); busy = 0; end
      begin
        while (busy || ndn < 22) begin
          @(negedge clk); dn_stop = ~dn_stop;
          repeat (2) @(negedge clk);
        end
        dn_stop = 1'b0;
      end
    join
    check_out("R9", 20, 1'b0);
    chk(stop_viol == 0, "R9", "chars issued after stop", stop_viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gaps();
    t_bad();
    t_ctrl();
    t_short();
    t_bp();
    t_toggle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule